// File: doc/BRIEF.md
# I2C Slave Controller with 7-bit and 10-bit Addressing

This block is an I2C bus slave that runs entirely on a fast system clock. It samples the open-drain SCL and SDA lines, finds START and STOP conditions, and shifts address and data bytes MSB first. It compares incoming addresses against one software-loaded address register. In 10-bit mode that register is reused for both halves of the address: software loads the high pattern first and swaps in the low byte once the high byte has matched.

Accepted bytes move from the shift register into a holding buffer, which sets the interrupt flag. The next byte can shift in while software has not yet read the buffer. A byte that completes while the buffer is still full is refused and raises a sticky overflow flag. For a read transfer, the byte that software wrote into the same buffer is shifted out on SDA. The block only ever pulls SDA low or releases it.

Top module: `i2c_tenbit_slave`

## Requirements
- R1: After reset, sda_pull, irq, ovf, buf_full and all status outputs are 0, and buf_rdata is 0x00.
- R2: The slave acts only when enable is 1 and mode is 4'b0110 (7-bit), 4'b0111 (10-bit), 4'b1110 (7-bit with START/STOP interrupt) or 4'b1111 (10-bit with START/STOP interrupt). In any other case it leaves sda_pull at 0 and its status unchanged, and a deasserted enable releases SDA on the next cycle.
- R3: A falling SDA while SCL is high sets st_start and clears st_stop. A rising SDA while SCL is high sets st_stop, clears st_start and ends the transfer. The two are never 1 together. In modes 111x, each START or STOP also sets irq.
- R4: In 7-bit mode, bits 7:1 of the first byte after START are compared with bits 7:1 of the address register, and bit 0 is the read/write flag. A match is acknowledged by pulling SDA low from the SCL fall after the 8th bit to the SCL fall after the 9th clock. A mismatch, including address 0x00 (no general call), is never acknowledged, and the slave ignores the bus until the next START.
- R5: In 10-bit mode, a first byte whose bits 7:1 equal address register bits 7:1, with bit 0 = 0, is acknowledged and sets st_reload. Writing the address register clears st_reload. The second byte must equal the whole register; it is then acknowledged and sets st_reload again. After a repeated START, the high byte with bit 0 = 1 selects a read, but only if the full 10-bit match happened since the last STOP.
- R6: A matched write address byte, and every data byte of a write, is copied into the buffer when it completes. The copy sets buf_full and irq, sets st_data to 0 for an address byte and 1 for a data byte, and acknowledges the byte. The next byte shifts in while the buffer is full.
- R7: A byte that completes while buf_full is 1 is not copied, leaves buf_rdata unchanged, sets ovf and gets no acknowledge. ovf stays 1 until ovf_clr.
- R8: A buf_rd pulse in the same cycle that a byte completes frees the buffer first, so the byte is accepted with no overflow.
- R9: After a matched read address, the buffer byte is driven MSB first, with sda_pull changing only while SCL is low. A master acknowledge reloads the next byte from the buffer and sets irq. A master non-acknowledge releases SDA for the rest of the transfer.
- R10: irq_clr clears irq and buf_rd clears buf_full. A set in the same cycle wins over the clear.
- R11: st_rw shows the read/write flag of the last matched address: 0 after a write address, 1 after a read address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| mode | input | 4 | Addressing and interrupt mode select |
| enable | input | 1 | Block enable |
| adr_wr | input | 1 | Write strobe for the address register |
| adr_wdata | input | 8 | Address register write data |
| buf_wr | input | 1 | Write strobe for the holding buffer |
| buf_wdata | input | 8 | Holding buffer write data |
| buf_rd | input | 1 | Buffer read strobe, frees the buffer |
| buf_rdata | output | 8 | Holding buffer contents |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq | output | 1 | Interrupt flag |
| ovf | output | 1 | Receive overflow flag |
| buf_full | output | 1 | Holding buffer holds an unread byte |
| st_start | output | 1 | START seen last |
| st_stop | output | 1 | STOP seen last |
| st_data | output | 1 | Last accepted byte was data (1) or address (0) |
| st_rw | output | 1 | Read/write flag of the last matched address |
| st_reload | output | 1 | Address register must be reloaded (10-bit) |

## Verification
The case that needs care is a byte completing in the same clock cycle as a software read of the holding buffer. The bench counts the synchronizer and edge-detect registers so that buf_rd is high in exactly the cycle where the 8th SCL rising edge is recognised. It then expects the byte to be accepted: the buffer takes the new value, the acknowledge is given, and ovf stays clear. The same sequence run with no read pulse must instead give an overflow with the buffer unchanged and no acknowledge. Every output is compared against a behavioural model on every clock, so a change in the wrong cycle is reported.

// File: rtl/i2c_tenbit_slave.sv
module i2c_tenbit_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic [3:0] mode,
  input  logic       enable,
  input  logic       adr_wr,
  input  logic [7:0] adr_wdata,
  input  logic       buf_wr,
  input  logic [7:0] buf_wdata,
  input  logic       buf_rd,
  output logic [7:0] buf_rdata,
  input  logic       irq_clr,
  input  logic       ovf_clr,
  output logic       irq,
  output logic       ovf,
  output logic       buf_full,
  output logic       st_start,
  output logic       st_stop,
  output logic       st_data,
  output logic       st_rw,
  output logic       st_reload
);

  typedef enum logic [2:0] {PH_IDLE, PH_HI, PH_LO, PH_RX, PH_TX, PH_SKIP} phase_t;

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic mode_ok, ten, ssirq;
  phase_t phase, nph, nph_f;
  logic [3:0] bitcnt;
  logic [7:0] sr, adr, byte_in;
  logic ack_q, ten_ok;
  logic hi_hit, lo_hit, cp, rdm, rl_set, accept;

  assign mode_ok = enable && (mode == 4'b0110 || mode == 4'b0111 ||
                              mode == 4'b1110 || mode == 4'b1111);
  assign ten   = mode[0];
  assign ssirq = mode[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s    = scl_q[SYNC_STAGES-1];
  assign sda_s    = sda_q[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  assign byte_in = {sr[6:0], sda_s};
  assign hi_hit  = (byte_in[7:1] == adr[7:1]);
  assign lo_hit  = (byte_in == adr);

  always_comb begin
    cp = 1'b0;
    rdm = 1'b0;
    rl_set = 1'b0;
    nph = PH_SKIP;
    case (phase)
      PH_HI: begin
        if (!ten) begin
          if (hi_hit && byte_in[0]) begin
            rdm = 1'b1;
            nph = PH_TX;
          end else if (hi_hit) begin
            cp = 1'b1;
            nph = PH_RX;
          end
        end else if (hi_hit && !byte_in[0]) begin
          cp = 1'b1;
          rl_set = 1'b1;
          nph = PH_LO;
        end else if (hi_hit && ten_ok) begin
          rdm = 1'b1;
          nph = PH_TX;
        end
      end
      PH_LO: if (lo_hit) begin
        cp = 1'b1;
        rl_set = 1'b1;
        nph = PH_RX;
      end
      PH_RX: begin
        cp = 1'b1;
        nph = PH_RX;
      end
      PH_TX: nph = PH_TX;
      default: nph = PH_SKIP;
    endcase
  end

  assign accept = cp && (!buf_full || buf_rd);
  assign nph_f  = (cp && !accept && phase != PH_RX) ? PH_SKIP : nph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      sr        <= '0;
      adr       <= '0;
      buf_rdata <= '0;
      ack_q     <= 1'b0;
      ten_ok    <= 1'b0;
      sda_pull  <= 1'b0;
      irq       <= 1'b0;
      ovf       <= 1'b0;
      buf_full  <= 1'b0;
      st_start  <= 1'b0;
      st_stop   <= 1'b0;
      st_data   <= 1'b0;
      st_rw     <= 1'b0;
      st_reload <= 1'b0;
    end else begin
      if (buf_rd)  buf_full <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (adr_wr) begin
        adr       <= adr_wdata;
        st_reload <= 1'b0;
      end
      if (buf_wr) buf_rdata <= buf_wdata;

      if (!mode_ok) begin
        phase    <= PH_IDLE;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        ack_q    <= 1'b0;
        ten_ok   <= 1'b0;
      end else if (start_c) begin
        phase    <= PH_HI;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        st_start <= 1'b1;
        st_stop  <= 1'b0;
        if (ssirq) irq <= 1'b1;
      end else if (stop_c) begin
        phase    <= PH_IDLE;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        ten_ok   <= 1'b0;
        st_stop  <= 1'b1;
        st_start <= 1'b0;
        if (ssirq) irq <= 1'b1;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (phase == PH_TX) begin
              if (!sda_s) begin
                sr  <= buf_rdata;
                irq <= 1'b1;
              end else begin
                phase <= PH_SKIP;
              end
            end
          end else begin
            sr     <= byte_in;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              phase <= nph_f;
              ack_q <= 1'b0;
              if (accept) begin
                buf_rdata <= byte_in;
                buf_full  <= 1'b1;
                irq       <= 1'b1;
                st_data   <= (phase == PH_RX);
                ack_q     <= 1'b1;
                if (phase != PH_RX) st_rw <= 1'b0;
                if (rl_set) st_reload <= 1'b1;
                if (phase == PH_LO) ten_ok <= 1'b1;
              end else if (cp) begin
                ovf <= 1'b1;
              end
              if (rdm) begin
                irq     <= 1'b1;
                st_data <= 1'b0;
                st_rw   <= 1'b1;
                ack_q   <= 1'b1;
              end
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8)      sda_pull <= ack_q;
          else if (phase == PH_TX) sda_pull <= ~sr[7];
          else                     sda_pull <= 1'b0;
        end
      end
    end
  end

endmodule

module i2c_tenbit_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       enable,
  input logic       sda_pull,
  input logic       ovf,
  input logic       ovf_clr,
  input logic       buf_full,
  input logic       buf_wr,
  input logic [7:0] buf_rdata,
  input logic       irq,
  input logic       st_start,
  input logic       st_stop
);

  // R2
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sda_pull);

  // R3
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_start && st_stop));

  // R9
  pull_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  // R7
  ovf_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) && !$past(buf_wr) |-> $stable(buf_rdata));

  // R6
  fill_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> irq);

endmodule

bind i2c_tenbit_slave i2c_tenbit_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .enable(enable),
  .sda_pull(sda_pull), .ovf(ovf), .ovf_clr(ovf_clr), .buf_full(buf_full),
  .buf_wr(buf_wr), .buf_rdata(buf_rdata), .irq(irq),
  .st_start(st_start), .st_stop(st_stop)
);

// File: tb/i2c_tenbit_slave_bench.sv
`timescale 1ns/1ps
module i2c_tenbit_slave_bench;
  localparam int HALF = 8;
  localparam int IDL = 0, HI = 1, LO = 2, RX = 3, TX = 4, SK = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [3:0] mode = 4'b0110;
  logic enable = 1'b0;
  logic adr_wr = 1'b0, buf_wr = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] adr_wdata = '0, buf_wdata = '0, buf_rdata;
  logic irq, ovf, buf_full, st_start, st_stop, st_data, st_rw, st_reload;
  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  i2c_tenbit_slave u_i2c_tenbit_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .mode(mode), .enable(enable), .adr_wr(adr_wr), .adr_wdata(adr_wdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .irq(irq), .ovf(ovf), .buf_full(buf_full),
    .st_start(st_start), .st_stop(st_stop), .st_data(st_data), .st_rw(st_rw),
    .st_reload(st_reload));

  int nchk = 0, nerr = 0;
  string cur = "R1";
  bit done = 0;

  // reference model state
  int m_ph = IDL, m_cnt = 0, m_byte = 0, m_tx = 0, m_adr = 0;
  bit m_on = 0, m_ten = 0, m_irqm = 0, m_ack = 0, m_tenok = 0, rd_now = 0, pulse_rd = 0;
  int e_buf = 0;
  bit e_pull = 0, e_irq = 0, e_ovf = 0, e_full = 0, e_start = 0, e_stop = 0;
  bit e_data = 0, e_rw = 0, e_reload = 0;

  task automatic chk1(string nm, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk1("sda_pull", int'(sda_pull), int'(e_pull));
    chk1("irq", int'(irq), int'(e_irq));
    chk1("ovf", int'(ovf), int'(e_ovf));
    chk1("buf_full", int'(buf_full), int'(e_full));
    chk1("buf_rdata", int'(buf_rdata), e_buf);
    chk1("st_start", int'(st_start), int'(e_start));
    chk1("st_stop", int'(st_stop), int'(e_stop));
    chk1("st_data", int'(st_data), int'(e_data));
    chk1("st_rw", int'(st_rw), int'(e_rw));
    chk1("st_reload", int'(st_reload), int'(e_reload));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  function automatic void m_start();
    if (!m_on) return;
    m_ph = HI; m_cnt = 0; e_pull = 0; e_start = 1; e_stop = 0;
    if (m_irqm) e_irq = 1;
  endfunction

  function automatic void m_stop();
    if (!m_on) return;
    m_ph = IDL; m_cnt = 0; e_pull = 0; e_stop = 1; e_start = 0; m_tenok = 0;
    if (m_irqm) e_irq = 1;
  endfunction

  function automatic void m_fall();
    if (!m_on || m_ph == IDL) return;
    if (m_cnt == 8) e_pull = m_ack;
    else if (m_ph == TX) e_pull = !((m_tx >> (7 - m_cnt)) & 1);
    else e_pull = 0;
  endfunction

  function automatic void m_rise(bit v);
    bit hit, cp, rd, rl, acc;
    int np;
    if (rd_now) e_full = 0;
    if (!m_on || m_ph == IDL) return;
    if (m_cnt == 8) begin
      m_cnt = 0;
      if (m_ph == TX) begin
        if (!v) begin m_tx = e_buf; e_irq = 1; end
        else m_ph = SK;
      end
      return;
    end
    m_byte = ((m_byte << 1) | int'(v)) & 255;
    m_cnt++;
    if (m_cnt != 8) return;
    hit = (m_byte >> 1) == (m_adr >> 1);
    cp = 0; rd = 0; rl = 0; np = SK;
    if (m_ph == HI) begin
      if (!m_ten) begin
        if (hit && (m_byte & 1)) begin rd = 1; np = TX; end
        else if (hit) begin cp = 1; np = RX; end
      end else if (hit && !(m_byte & 1)) begin cp = 1; rl = 1; np = LO; end
      else if (hit && m_tenok) begin rd = 1; np = TX; end
    end else if (m_ph == LO) begin
      if (m_byte == m_adr) begin cp = 1; rl = 1; np = RX; end
    end else if (m_ph == RX) begin cp = 1; np = RX; end
    else if (m_ph == TX) np = TX;
    acc = cp && !e_full;
    if (cp && !acc && m_ph != RX) np = SK;
    m_ack = 0;
    if (acc) begin
      e_buf = m_byte; e_full = 1; e_irq = 1; e_data = (m_ph == RX); m_ack = 1;
      if (m_ph != RX) e_rw = 0;
      if (rl) e_reload = 1;
      if (m_ph == LO) m_tenok = 1;
    end else if (cp) e_ovf = 1;
    if (rd) begin e_irq = 1; e_data = 0; e_rw = 1; m_ack = 1; end
    m_ph = np;
  endfunction

  task automatic line(input bit c, input bit d);
    bit os, ol, nl;
    os = scl_m; ol = sda_line;
    scl_m = c; sda_m = d;
    nl = d & ~sda_pull;
    tick();
    tick();
    if (pulse_rd && !os && c) buf_rd = 1'b1;
    @(negedge clk);
    rd_now = buf_rd; buf_rd = 1'b0;
    if (!os && c) m_rise(nl);
    else if (os && !c) m_fall();
    else if (os && c && ol && !nl) m_start();
    else if (os && c && !ol && nl) m_stop();
    rd_now = 0;
    compare();
    repeat (HALF - 3) tick();
  endtask

  task automatic mbit(input bit b);
    line(1'b0, b); line(1'b1, b); line(1'b0, b);
  endtask

  task automatic start_c();
    line(1'b0, 1'b1); line(1'b1, 1'b1); line(1'b1, 1'b0); line(1'b0, 1'b0);
  endtask

  task automatic stop_c();
    line(1'b0, 1'b0); line(1'b1, 1'b0); line(1'b1, 1'b1);
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit rdp, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      pulse_rd = rdp && (i == 0);
      mbit(b[i]);
      pulse_rd = 0;
    end
    line(1'b0, 1'b1); line(1'b1, 1'b1);
    ack = !sda_line;
    line(1'b0, 1'b1);
  endtask

  task automatic rd_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      line(1'b0, 1'b1); line(1'b1, 1'b1);
      v[i] = sda_line;
      line(1'b0, 1'b1);
    end
  endtask

  task automatic sw_adr(input logic [7:0] v);
    adr_wr = 1'b1; adr_wdata = v;
    @(negedge clk); adr_wr = 1'b0;
    m_adr = int'(v); e_reload = 0; compare();
  endtask

  task automatic sw_wr(input logic [7:0] v);
    buf_wr = 1'b1; buf_wdata = v;
    @(negedge clk); buf_wr = 1'b0;
    e_buf = int'(v); compare();
  endtask

  task automatic sw_rd();
    buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; e_full = 0; compare();
  endtask

  task automatic sw_iclr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; e_irq = 0; compare();
  endtask

  task automatic sw_oclr();
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; e_ovf = 0; compare();
  endtask

  task automatic sw_mode(input logic [3:0] m, input bit en);
    mode = m; enable = en;
    @(negedge clk);
    m_on = en && (m == 4'b0110 || m == 4'b0111 || m == 4'b1110 || m == 4'b1111);
    m_ten = m[0]; m_irqm = m[3];
    if (!m_on) begin m_ph = IDL; m_cnt = 0; e_pull = 0; m_tenok = 0; end
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL %s watchdog act=running exp=finished", cur);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur = "R1"; tick();

    cur = "R2";
    sw_adr(8'h84);
    start_c(); wr_byte(8'h84, 0, a);
    chk1("ack_disabled", int'(a), 0);
    stop_c();

    cur = "R4";
    sw_mode(4'b0110, 1'b1);
    start_c(); wr_byte(8'h84, 0, a);
    chk1("addr7_ack", int'(a), 1);
    cur = "R11"; chk1("st_rw_write", int'(st_rw), 0);
    cur = "R10"; sw_rd(); sw_iclr();
    cur = "R6"; wr_byte(8'h5A, 0, a);
    chk1("data_ack", int'(a), 1);
    chk1("buf_data", int'(buf_rdata), 8'h5A);
    cur = "R3"; stop_c();

    cur = "R4";
    sw_rd(); sw_iclr();
    start_c(); wr_byte(8'h00, 0, a);
    chk1("gencall_nack", int'(a), 0);
    wr_byte(8'h33, 0, a);
    chk1("skip_nack", int'(a), 0);
    stop_c();

    cur = "R7";
    start_c(); wr_byte(8'h84, 0, a);
    wr_byte(8'h11, 0, a);
    chk1("ovf_nack", int'(a), 0);
    chk1("ovf_buf", int'(buf_rdata), 8'h84);
    wr_byte(8'h12, 0, a);
    sw_oclr();
    cur = "R8"; wr_byte(8'h22, 1, a);
    chk1("same_cycle_ack", int'(a), 1);
    chk1("same_cycle_buf", int'(buf_rdata), 8'h22);
    chk1("same_cycle_ovf", int'(ovf), 0);
    stop_c();

    cur = "R3";
    sw_mode(4'b1110, 1'b1); sw_rd(); sw_iclr();
    start_c(); sw_iclr(); stop_c(); sw_iclr();

    cur = "R5";
    sw_mode(4'b0111, 1'b1); sw_adr(8'hF2);
    start_c(); wr_byte(8'hF2, 0, a);
    chk1("hi_ack", int'(a), 1);
    chk1("reload_set", int'(st_reload), 1);
    sw_rd(); sw_adr(8'h3C);
    wr_byte(8'h3C, 0, a);
    chk1("lo_ack", int'(a), 1);
    sw_rd(); sw_iclr();
    wr_byte(8'h99, 0, a);
    sw_rd(); sw_adr(8'hF2);
    cur = "R9"; sw_wr(8'hA5); sw_iclr();
    start_c(); wr_byte(8'hF3, 0, a);
    chk1("read_addr_ack", int'(a), 1);
    cur = "R11"; chk1("st_rw_read", int'(st_rw), 1);
    cur = "R9"; sw_iclr();
    rd_byte(v); chk1("tx_byte0", int'(v), 8'hA5);
    sw_wr(8'hC3); mbit(1'b0);
    rd_byte(v); chk1("tx_byte1", int'(v), 8'hC3);
    mbit(1'b1); stop_c();

    cur = "R5";
    sw_iclr();
    start_c(); wr_byte(8'hF3, 0, a);
    chk1("read_no_match", int'(a), 0);
    stop_c();
    start_c(); wr_byte(8'hF2, 0, a); sw_rd(); sw_adr(8'h3D);
    wr_byte(8'h3C, 0, a);
    chk1("lo_mismatch", int'(a), 0);
    stop_c();

    cur = "R2"; sw_mode(4'b0111, 1'b0); tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule